// File: doc/BRIEF.md
# Serial Programming Port for a Dual-Loop Synthesiser

This block receives configuration words for a two-loop frequency synthesiser over a three-wire write-only serial link: a serial data line, a serial clock and an active-low frame enable. While the enable is low, each rising serial clock edge pushes one bit into a 19-bit frame register. When the enable returns high, the frame is split into a 16-bit payload and a 3-bit address, and the payload is written into one of four held registers: the RF main divider ratio, the reference divider ratio, the IF main divider ratio or the control word.

The three link inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and all edge detection takes place in the system clock domain. A small state machine with three states sequences the port. In `ST_IDLE` the enable is high and serial clocks are ignored. In `ST_SHIFT` the enable is low and bits are accepted. `ST_COMMIT` lasts one cycle and writes the frame. The transitions are `IDLE->SHIFT` when the synchronised enable is low, `SHIFT->COMMIT` when it is high again, and `COMMIT->IDLE` unconditionally. Each register has its own one-cycle update strobe so the divider logic downstream knows when to take a new value. The registers keep their contents for as long as the block is not reset, so a low-power period of the synthesiser needs no reprogramming, and frames are always accepted.

Top module: `synprog_top`

## Requirements
- R1: After a synchronous active-high reset, the RF divider output reads 10410, the reference divider 13, the IF divider 178 and the control word 0x0E12, and all four update strobes are low.
- R2: Serial clock edges that occur while the enable is high do not change the frame register: a later short frame observes the stale bits exactly as they were before those edges.
- R3: A 19-bit frame is taken in the order it arrives. The first bit becomes payload bit 0 and the 16th becomes payload bit 15. The 17th, 18th and 19th bits form the address, with the 17th as address bit 2 (MSB) and the 19th as address bit 0.
- R4: When more than 19 bits arrive in one frame, only the last 19 are used and the earlier ones are dropped without any indication.
- R5: A frame with fewer than 19 bits still loads on the rising edge of the enable. The frame register shifts one place toward payload bit 0 per received bit, so the missing leading positions hold the bits left over from earlier frames. The frame register is all zeros after reset.
- R6: Address 0 writes the RF divider, 1 the reference divider, 2 the IF divider and 3 the control word. Addresses 4 to 7 write nothing and raise no strobe.
- R7: A load happens only after the enable rises. The addressed register's strobe is high for exactly one cycle, in the first cycle the new value is visible on its output, and at most one strobe is high in any cycle.
- R8: A load leaves the three registers it does not address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous; rising edge accepts a bit |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Frame enable, active low, asynchronous |
| rf_div | output | 16 | RF main divider ratio |
| ref_div | output | 16 | Reference divider ratio |
| if_div | output | 16 | IF main divider ratio |
| ctrl_word | output | 16 | Control word |
| rf_upd | output | 1 | One-cycle strobe: rf_div was just written |
| ref_upd | output | 1 | One-cycle strobe: ref_div was just written |
| if_upd | output | 1 | One-cycle strobe: if_div was just written |
| ctrl_upd | output | 1 | One-cycle strobe: ctrl_word was just written |

## Verification
Full 19-bit frames sweep all eight addresses with all-zero, all-one and address-dependent payloads. This separates a wrong address decode, a missing ignore of addresses 4 to 7 and writes that reach neighbouring registers. A walking-one payload at a single address shows any bit-order or reversal error in the payload field. Over-long frames with leading junk show whether only the last 19 bits are kept. Serial clocks sent with the enable high, followed by short frames, show whether stale bits are kept correctly and whether edges outside a frame leak into the shift register.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int FRAME_W  = DATA_W + ADDR_W;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } prog_state_t;

    // Power-on contents, indexed by register address
    function automatic logic [DATA_W-1:0] preset_value(input int idx);
        case (idx)
            0:       preset_value = DATA_W'(10410);
            1:       preset_value = DATA_W'(13);
            2:       preset_value = DATA_W'(178);
            default: preset_value = DATA_W'(16'h0E12);
        endcase
    endfunction
endpackage

// File: rtl/synprog_sync.sv
module synprog_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= RST_VAL[i];
                stage2_q[i] <= RST_VAL[i];
            end else begin
                stage1_q[i] <= async_in[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/synprog_shifter.sv
module synprog_shifter #(
    parameter int FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame_q
);
    // New bits enter at the top and move toward bit 0, so the oldest of
    // the last FRAME_W bits ends up in position 0.
    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= '0;
        else if (shift_en)
            frame_q <= {bit_in, frame_q[FRAME_W-1:1]};
    end
endmodule

// File: rtl/synprog_regbank.sv
module synprog_regbank
    import synprog_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [NUM_REGS-1:0]              upd_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = load && (addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= preset_value(i);
                upd_q[i]  <= 1'b0;
            end else begin
                upd_q[i] <= hit;
                if (hit)
                    regs_q[i] <= data;
            end
        end

        // R3: the strobed register shows the payload presented at the load
        p_load_value_r3: assert property (@(posedge clk) disable iff (rst)
            upd_q[i] |-> regs_q[i] == $past(data));

        // R8: without its strobe a register keeps its value
        p_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (!upd_q[i] && !$past(rst)) |-> $stable(regs_q[i]));
    end

    // R7: never more than one strobe at a time
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_q));
endmodule

// File: rtl/synprog_top.sv
module synprog_top
    import synprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en_n,
    output logic [DATA_W-1:0] rf_div,
    output logic [DATA_W-1:0] ref_div,
    output logic [DATA_W-1:0] if_div,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              rf_upd,
    output logic              ref_upd,
    output logic              if_upd,
    output logic              ctrl_upd
);
    // Synchronised inputs: {enable, clock, data}; enable idles high
    logic [2:0] sync_v;
    synprog_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_en_n, ser_clk, ser_dat}),
        .sync_out (sync_v)
    );

    logic en_n_s, sclk_s, sdat_s;
    assign en_n_s = sync_v[2];
    assign sclk_s = sync_v[1];
    assign sdat_s = sync_v[0];

    logic sclk_prev_q;
    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    logic sclk_rise;
    assign sclk_rise = sclk_s && !sclk_prev_q;

    // State register
    prog_state_t state_q, state_d;
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state and outputs
    logic shift_en, commit;
    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!en_n_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                shift_en = sclk_rise;
                if (en_n_s) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    logic [FRAME_W-1:0] frame_q;
    synprog_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sdat_s),
        .frame_q  (frame_q)
    );

    // Address: earliest of the trailing bits is the MSB
    logic [ADDR_W-1:0] frame_addr;
    always_comb begin
        for (int k = 0; k < ADDR_W; k++)
            frame_addr[ADDR_W-1-k] = frame_q[DATA_W+k];
    end

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_REGS-1:0]             upd;
    synprog_regbank u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (commit),
        .addr   (frame_addr),
        .data   (frame_q[DATA_W-1:0]),
        .regs_q (regs),
        .upd_q  (upd)
    );

    assign rf_div    = regs[0];
    assign ref_div   = regs[1];
    assign if_div    = regs[2];
    assign ctrl_word = regs[3];
    assign rf_upd    = upd[0];
    assign ref_upd   = upd[1];
    assign if_upd    = upd[2];
    assign ctrl_upd  = upd[3];

    // R2: the frame register moves only while a frame is open
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SHIFT) |=> $stable(frame_q));

    // R7: a strobe always follows the commit state
    p_strobe_after_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (|upd) |-> $past(state_q) == ST_COMMIT);

    // R7: no commit without a preceding open frame
    p_commit_from_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |-> $past(state_q) == ST_SHIFT);
endmodule

// File: tb/tb_synprog_top.sv
module tb_synprog_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic sen_n = 1'b1;
    logic [15:0] rf_div, ref_div, if_div, ctrl_word;
    logic rf_upd, ref_upd, if_upd, ctrl_upd;

    always #4 clk = ~clk;   // 125 MHz

    synprog_top dut (
        .clk(clk), .rst(rst), .ser_clk(sclk), .ser_dat(sdat), .ser_en_n(sen_n),
        .rf_div(rf_div), .ref_div(ref_div), .if_div(if_div), .ctrl_word(ctrl_word),
        .rf_upd(rf_upd), .ref_upd(ref_upd), .if_upd(if_upd), .ctrl_upd(ctrl_upd)
    );

    int checks = 0;
    int errors = 0;
    logic [18:0] model_sr = '0;
    logic [15:0] exp_regs [4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] get_reg(input int r);
        case (r)
            0: get_reg = rf_div;
            1: get_reg = ref_div;
            2: get_reg = if_div;
            default: get_reg = ctrl_word;
        endcase
    endfunction

    function automatic logic [3:0] get_upd();
        get_upd = {ctrl_upd, if_upd, ref_upd, rf_upd};
    endfunction

    // Bit 0 of the result is sent first
    function automatic logic [18:0] mk_frame(input logic [2:0] a, input logic [15:0] d);
        mk_frame = {a[0], a[1], a[2], d};
    endfunction

    // Serial clock pulses with the enable high: must be ignored (R2)
    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sdat = i[0];
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (6) @(negedge clk); sclk = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic run_frame(input int n, input logic [31:0] bits, input string tag);
        int cnt [4];
        logic [15:0] cap [4];
        logic [2:0] a;
        logic [15:0] d;
        for (int r = 0; r < 4; r++) begin cnt[r] = 0; cap[r] = '0; end
        @(negedge clk); sen_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdat = bits[i];
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (6) @(negedge clk); sclk = 1'b0;
            repeat (6) @(negedge clk);
            model_sr = {bits[i], model_sr[18:1]};
        end
        sen_n = 1'b1;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            for (int r = 0; r < 4; r++)
                if (get_upd()[r]) begin cnt[r]++; cap[r] = get_reg(r); end
        end
        a = {model_sr[16], model_sr[17], model_sr[18]};
        d = model_sr[15:0];
        if (a < 3'd4) exp_regs[a] = d;
        for (int r = 0; r < 4; r++) begin
            if (a == 3'(r)) begin
                chk(cnt[r] == 1, "R7 strobe count", cnt[r], 1);
                chk(cap[r] == d, "R7 value at strobe", cap[r], d);
                chk(get_reg(r) == d, tag, get_reg(r), d);
            end else begin
                chk(cnt[r] == 0, (a >= 3'd4) ? "R6 no strobe" : "R7 stray strobe", cnt[r], 0);
                chk(get_reg(r) == exp_regs[r], (a >= 3'd4) ? "R6 unaddressed" : "R8 untouched",
                    get_reg(r), exp_regs[r]);
            end
        end
    endtask

    initial begin
        for (int r = 0; r < 4; r++) exp_regs[r] = '0;
        exp_regs[0] = 16'd10410; exp_regs[1] = 16'd13;
        exp_regs[2] = 16'd178;   exp_regs[3] = 16'h0E12;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        for (int r = 0; r < 4; r++)
            chk(get_reg(r) == exp_regs[r], "R1 preset", get_reg(r), exp_regs[r]);
        chk(get_upd() == 4'b0, "R1 strobes low", get_upd(), 0);

        // Address sweep with several payloads (R3, R6, R8)
        for (int a = 0; a < 8; a++) begin
            run_frame(19, 32'(mk_frame(3'(a), 16'h0000)), "R6 decode zero");
            run_frame(19, 32'(mk_frame(3'(a), 16'hFFFF)), "R6 decode ones");
            run_frame(19, 32'(mk_frame(3'(a), 16'h5A3C ^ 16'(a * 16'h1111))), "R6 decode mix");
        end

        // Walking one through the payload (R3 bit order)
        for (int b = 0; b < 16; b++)
            run_frame(19, 32'(mk_frame(3'd1, 16'(1 << b))), "R3 bit order");
        run_frame(19, 32'(mk_frame(3'd3, 16'h8001)), "R3 control order");

        // Over-long frame: 6 junk ones first (R4)
        run_frame(25, {7'b0, mk_frame(3'd2, 16'h1234), 6'b111111}, "R4 last bits kept");
        run_frame(23, {9'b0, mk_frame(3'd0, 16'hBEEF), 4'b1010}, "R4 last bits kept");

        // Ignored clocks, then short frames using stale bits (R2, R5)
        run_frame(19, 32'(mk_frame(3'd0, 16'hC3A5)), "R3 setup");
        idle_clocks(10);
        run_frame(3, 32'b011, "R2 ignored clocks");
        run_frame(10, 32'b1100101101, "R5 short frame");
        idle_clocks(5);
        run_frame(1, 32'b1, "R5 single bit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule